// File: doc/BRIEF.md
# Configuration Port Register Block

This block is the software-visible register file of a device-configuration port. A host reaches it over a plain 32-bit write/read bus addressed by byte offset. It holds the port control word, a lock word, the interrupt status and mask words, a status word, the DMA source and destination addresses and lengths, and a miscellaneous control word. The control bits drive the fabric program line (active low), the partial-reconfiguration enable, the port enable and the internal loopback select. The block accepts no write until the host presents a fixed unlock key.

Writing the source length queues a DMA command in a short command queue. A model of the configuration DMA engine reports back through event pulses: the bus side finished, the configuration side finished, the fabric is programmed, and error conditions. These pulses set sticky interrupt status bits, which the host clears by writing ones. Bit 0 of the source address, captured with each command, picks the completion rule. When it is clear, the bus side alone completes the command. When it is set, completion waits until both sides have finished, and the combined done bit is raised as well. A registered, active-high interrupt is asserted while any unmasked status bit is set.

Top module: `cfgport_regs`

## Requirements
- R1: After reset the control word reads 0x40000000, so the program line is high. The mask reads 0xF8F7F87F. The interrupt status reads 0, the irq output is 0 and the block is locked.
- R2: While the block is locked, a write to any offset other than 0x34 leaves every register unchanged, and reads still return register contents.
- R3: Writing 0x757BDF0D to offset 0x34 unlocks the block for good. Any other value written there leaves it locked.
- R4: Control (0x00) bit 30 drives prog_n, bit 27 drives pr_en and bit 26 drives port_en. Miscellaneous control (0x80) bit 4 drives loopback.
- R5: Lock (0x04), source address (0x18), destination address (0x1C), destination length (0x24) and the control words read back what was written. Mask (0x10) keeps only the bits of 0xF8F7F87F. Unmapped offsets read 0.
- R6: Writing ones to interrupt status (0x0C) clears those bits. An event that sets a bit in the same cycle wins over its clear.
- R7: Status (0x14) bit 4 follows the fab_init input. Status bit 31 is 1 while the command queue holds QDEPTH (4) commands. Each write to source length (0x20) adds one command.
- R8: For a command queued with source-address bit 0 clear, dma_done_evt sets status bit 13 only and retires the command. A cfg_done_evt alone neither sets a bit nor retires it.
- R9: For a command queued with source-address bit 0 set, bits 13 and 12 are both set only once dma_done_evt and cfg_done_evt have each occurred, in either order. Then the command retires.
- R10: prog_done_evt sets interrupt status bit 2. err_evt[3:0] set bits 23:20.
- R11: irq equals, one clock later, the OR of the interrupt status bits whose mask bits are 0.
- R12: A source-length write while the queue is full is dropped. Completion events while the queue is empty set nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dma_done_evt | input | 1 | Bus side of the head command finished |
| cfg_done_evt | input | 1 | Configuration side of the head command finished |
| prog_done_evt | input | 1 | Fabric reports programmed |
| err_evt | input | 4 | Error event pulses |
| fab_init | input | 1 | Fabric init level |
| irq | output | 1 | Registered interrupt, active high |
| prog_n | output | 1 | Fabric program line, active low |
| pr_en | output | 1 | Partial reconfiguration enable |
| port_en | output | 1 | Configuration port enable |
| loopback | output | 1 | Internal port loopback select |

## Verification
The hardest situations to reach are the held-off completion, which needs the two side events delivered in both orders for a command flagged through the source address, and the full queue, where the dropped fifth command only shows up as a missing completion after four retirements. The stimulus queues commands with chosen address bits, pulses the events one at a time and reads status between pulses. It also drives a programmed event and its write-one clear in the same cycle to show that the set wins.

// File: rtl/cfgport_regs.sv
module cfgport_regs #(
  parameter int          ADDR_W     = 8,
  parameter int          QDEPTH     = 4,
  parameter logic [31:0] UNLOCK_KEY = 32'h757B_DF0D,
  parameter logic [31:0] CTRL_RST   = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dma_done_evt,
  input  logic              cfg_done_evt,
  input  logic              prog_done_evt,
  input  logic [3:0]        err_evt,
  input  logic              fab_init,
  output logic              irq,
  output logic              prog_n,
  output logic              pr_en,
  output logic              port_en,
  output logic              loopback
);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW = $clog2(QDEPTH + 1);
  localparam logic [31:0] IMPL = 32'hF8F7_F87F;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_ISTS  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_IMSK  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_SADR  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_DADR  = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_SLEN  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_DLEN  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_UNLK  = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] A_MISC  = ADDR_W'('h80);

  logic        unlocked;
  logic [31:0] ctrl, lockw, ists, imask, sadr, dadr, slen, dlen, misc;
  logic [QDEPTH-1:0] qflag;
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] q_cnt;
  logic          bus_seen, cfg_seen;

  wire wr_ok     = bus_wr && unlocked;
  wire q_full    = (q_cnt == CW'(QDEPTH));
  wire q_empty   = (q_cnt == '0);
  wire push      = wr_ok && bus_addr == A_SLEN && !q_full;
  wire head_flag = qflag[rp];
  wire bus_n     = bus_seen | dma_done_evt;
  wire cfg_n     = cfg_seen | cfg_done_evt;
  wire pop       = !q_empty && (head_flag ? (bus_n && cfg_n) : bus_n);

  wire [31:0] set_bits = ({18'd0, pop, pop && head_flag, 12'd0})
                       | {8'd0, err_evt, 17'd0, prog_done_evt, 2'd0};
  wire [31:0] clr_bits = (wr_ok && bus_addr == A_ISTS) ? bus_wdata : 32'd0;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      ctrl  <= CTRL_RST;
      lockw <= '0;
      imask <= IMPL;
      sadr  <= '0;
      dadr  <= '0;
      slen  <= '0;
      dlen  <= '0;
      misc  <= '0;
    end else begin
      if (bus_wr && bus_addr == A_UNLK && bus_wdata == UNLOCK_KEY) unlocked <= 1'b1;
      if (wr_ok) begin
        case (bus_addr)
          A_CTRL: ctrl  <= bus_wdata;
          A_LOCK: lockw <= bus_wdata;
          A_IMSK: imask <= bus_wdata & IMPL;
          A_SADR: sadr  <= bus_wdata;
          A_DADR: dadr  <= bus_wdata;
          A_SLEN: slen  <= bus_wdata;
          A_DLEN: dlen  <= bus_wdata;
          A_MISC: misc  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ists <= '0;
      irq  <= 1'b0;
    end else begin
      ists <= ((ists & ~clr_bits) | set_bits) & IMPL;
      irq  <= |(ists & ~imask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qflag    <= '0;
      rp       <= '0;
      wp       <= '0;
      q_cnt    <= '0;
      bus_seen <= 1'b0;
      cfg_seen <= 1'b0;
    end else begin
      if (push) begin
        qflag[wp] <= sadr[0];
        wp        <= nxt(wp);
      end
      if (pop) begin
        rp       <= nxt(rp);
        bus_seen <= 1'b0;
        cfg_seen <= 1'b0;
      end else if (!q_empty) begin
        bus_seen <= bus_n;
        cfg_seen <= cfg_n;
      end
      q_cnt <= q_cnt + CW'(push) - CW'(pop);
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_LOCK:  bus_rdata = lockw;
      A_ISTS:  bus_rdata = ists;
      A_IMSK:  bus_rdata = imask;
      A_STAT:  bus_rdata = {q_full, 26'd0, fab_init, 4'd0};
      A_SADR:  bus_rdata = sadr;
      A_DADR:  bus_rdata = dadr;
      A_SLEN:  bus_rdata = slen;
      A_DLEN:  bus_rdata = dlen;
      A_MISC:  bus_rdata = misc;
      default: bus_rdata = 32'd0;
    endcase
  end

  assign prog_n   = ctrl[30];
  assign pr_en    = ctrl[27];
  assign port_en  = ctrl[26];
  assign loopback = misc[4];
endmodule

module cfgport_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int CW     = 3,
  parameter int QDEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              unlocked,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       ctrl,
  input logic [31:0]       ists,
  input logic [31:0]       imask,
  input logic [CW-1:0]     q_cnt,
  input logic              prog_done_evt,
  input logic              irq
);
  AST_LOCKED_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n) !$past(unlocked) |-> $stable(ctrl)); // R2
  AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(unlocked) |-> unlocked); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) $past(unlocked && bus_wr && bus_addr == ADDR_W'('h0C) && bus_wdata[2] && !prog_done_evt) |-> !ists[2]); // R6
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) q_cnt <= CW'(QDEPTH)); // R7
  AST_DP_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n) $rose(ists[12]) |-> $past(q_cnt) != '0); // R9
  AST_PROG_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n) $past(prog_done_evt) |-> ists[2]); // R10
  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n) irq == $past(|(ists & ~imask))); // R11
endmodule

bind cfgport_regs cfgport_regs_chk #(.ADDR_W(ADDR_W), .CW(CW), .QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctrl(ctrl), .ists(ists), .imask(imask), .q_cnt(q_cnt),
  .prog_done_evt(prog_done_evt), .irq(irq)
);

// File: tb/cfgport_regs_bench.sv
module cfgport_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic dma_done_evt = 1'b0, cfg_done_evt = 1'b0, prog_done_evt = 1'b0, fab_init = 1'b0;
  logic [3:0] err_evt = '0;
  logic irq, prog_n, pr_en, port_en, loopback;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfgport_regs u_cfgport_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dma_done_evt(dma_done_evt), .cfg_done_evt(cfg_done_evt),
    .prog_done_evt(prog_done_evt), .err_evt(err_evt), .fab_init(fab_init), .irq(irq),
    .prog_n(prog_n), .pr_en(pr_en), .port_en(port_en), .loopback(loopback)
  );

  // {offset, write data, expected read-back}; R5
  localparam logic [71:0] VECS [9] = '{
    {8'h00, 32'h0C00_0000, 32'h0C00_0000},
    {8'h04, 32'h1234_5678, 32'h1234_5678},
    {8'h18, 32'h1000_0001, 32'h1000_0001},
    {8'h1C, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {8'h24, 32'h0000_0000, 32'h0000_0000},
    {8'h80, 32'h0000_0010, 32'h0000_0010},
    {8'h10, 32'hFFFF_FFFF, 32'hF8F7_F87F},
    {8'h0C, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h40, 32'h0000_DEAD, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: dma_done_evt = 1'b1;
      1: cfg_done_evt = 1'b1;
      default: prog_done_evt = 1'b1;
    endcase
    @(negedge clk);
    dma_done_evt = 1'b0; cfg_done_evt = 1'b0; prog_done_evt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 ctrl", 8'h00, 32'h4000_0000);
    rd("R1 mask", 8'h10, 32'hF8F7_F87F);
    rd("R1 ists", 8'h0C, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 prog_n", {31'd0, prog_n}, 32'd1);

    wr(8'h04, 32'hAAAA_5555);
    rd("R2 locked lock write", 8'h04, 32'h0);
    wr(8'h00, 32'h0);
    chk("R2 locked ctrl write", {31'd0, prog_n}, 32'd1);
    wr(8'h34, 32'h757B_DF0C);
    wr(8'h04, 32'h0000_0001);
    rd("R3 wrong key", 8'h04, 32'h0);
    wr(8'h34, 32'h757B_DF0D);

    for (int i = 0; i < 9; i++) begin
      wr(VECS[i][71:64], VECS[i][63:32]);
      rd("R5 readback", VECS[i][71:64], VECS[i][31:0]);
    end

    chk("R4 prog_n", {31'd0, prog_n}, 32'd0);
    chk("R4 pr_en", {31'd0, pr_en}, 32'd1);
    chk("R4 port_en", {31'd0, port_en}, 32'd1);
    chk("R4 loopback", {31'd0, loopback}, 32'd1);

    wr(8'h10, 32'h0);
    chk("R11 idle irq", {31'd0, irq}, 32'd0);
    pulse(2);
    rd("R10 prog done", 8'h0C, 32'h4);
    chk("R11 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R11 irq set", {31'd0, irq}, 32'd1);
    wr(8'h0C, 32'h4);
    rd("R6 w1c", 8'h0C, 32'h0);
    @(negedge clk);
    chk("R11 irq clear", {31'd0, irq}, 32'd0);

    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h4; prog_done_evt = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; prog_done_evt = 1'b0;
    rd("R6 set wins", 8'h0C, 32'h4);
    wr(8'h0C, 32'hFFFF_FFFF);

    @(negedge clk); err_evt = 4'b1010;
    @(negedge clk); err_evt = 4'b0000;
    rd("R10 errors", 8'h0C, 32'h00A0_0000);
    wr(8'h0C, 32'hFFFF_FFFF);

    wr(8'h18, 32'h0000_1000);
    wr(8'h20, 32'd8);
    rd("R7 one queued", 8'h14, 32'h0);
    pulse(1);
    rd("R8 cfg alone", 8'h0C, 32'h0);
    pulse(0);
    rd("R8 bus done", 8'h0C, 32'h2000);
    wr(8'h0C, 32'hFFFF_FFFF);
    pulse(0);
    rd("R12 empty event", 8'h0C, 32'h0);

    wr(8'h18, 32'h0000_1001);
    wr(8'h20, 32'd4);
    pulse(0);
    rd("R9 bus only held", 8'h0C, 32'h0);
    pulse(1);
    rd("R9 both done", 8'h0C, 32'h3000);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h20, 32'd4);
    pulse(1);
    rd("R9 cfg only held", 8'h0C, 32'h0);
    pulse(0);
    rd("R9 reverse order", 8'h0C, 32'h3000);
    wr(8'h0C, 32'hFFFF_FFFF);

    fab_init = 1'b1;
    rd("R7 init", 8'h14, 32'h10);
    fab_init = 1'b0;
    wr(8'h18, 32'h0);
    for (int i = 0; i < 4; i++) wr(8'h20, 32'd1);
    rd("R7 full", 8'h14, 32'h8000_0000);
    wr(8'h20, 32'd1);
    for (int i = 0; i < 4; i++) pulse(0);
    rd("R8 pops", 8'h0C, 32'h2000);
    rd("R7 drained", 8'h14, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    pulse(0);
    rd("R12 fifth dropped", 8'h0C, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule